// File: doc/BRIEF.md
# Static memory timing calculator

This block turns nanosecond timing requests for an external static memory bus into clock-cycle counts for a memory controller. For the read side it takes the chip-select setup and width, the read-strobe setup and width and the total read cycle length; the write side has the same five values for chip select and write strobe. Four optional hold (recovery) times, one for each strobe, also come in. A scale factor derived from the controller clock frequency converts every value into cycles, always rounding up.

Each total cycle length is then stretched so that both strobes on its side fit inside it: setup, width and hold end to end. Every result is clamped to the width of the output fields, and a flag reports any clamping. A `start` pulse latches the frequency and all fourteen requests. One shared multiplier then converts one value per clock, and `done` pulses once when all ten results are valid.

Top module: `smem_timing_calc`

## Requirements
- R1: On `start`, scale = ((freq_hz / 10000) << 16) / 100000 in integer arithmetic. Each nonzero request x converts to (x * scale + 65535) >> 16 cycles, so the result is always rounded up.
- R2: A setup, width or total request of 0 ns gives a count of 0, whatever the frequency.
- R3: A hold request of 0 ns counts as 1 cycle. A nonzero hold converts as in R1.
- R4: The read total is max(converted read total, cs setup + cs width + cs hold, strobe setup + strobe width + strobe hold), all taken on the read side and computed before any clamping.
- R5: The write total is extended the same way from the write-side chip-select and write-strobe values.
- R6: Any output whose full value exceeds 2^CYC_W - 1 (127 by default) is clamped to that value. `overflow` is 1 exactly when at least one of the ten outputs was clamped.
- R7: `busy` is high from the clock after an accepted `start` until `done` rises. `done` rises on the 15th rising edge after the edge that accepts `start` and stays high for exactly one cycle. The outputs and `overflow` change only on that edge.
- R8: A `start` seen while `busy` is high is ignored. Changes on the request and frequency inputs after the accepting edge do not affect the results.
- R9: After reset all outputs, `overflow`, `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calculation (taken only when not busy) |
| freq_hz | input | 32 | Controller clock frequency in Hz |
| rd_cs_setup_ns | input | 16 | Read chip-select setup |
| rd_strb_setup_ns | input | 16 | Read strobe setup |
| wr_cs_setup_ns | input | 16 | Write chip-select setup |
| wr_strb_setup_ns | input | 16 | Write strobe setup |
| rd_cs_width_ns | input | 16 | Read chip-select width |
| rd_strb_width_ns | input | 16 | Read strobe width |
| wr_cs_width_ns | input | 16 | Write chip-select width |
| wr_strb_width_ns | input | 16 | Write strobe width |
| rd_total_ns | input | 16 | Requested total read cycle |
| wr_total_ns | input | 16 | Requested total write cycle |
| rd_cs_hold_ns | input | 16 | Read chip-select hold, 0 means one cycle |
| rd_strb_hold_ns | input | 16 | Read strobe hold, 0 means one cycle |
| wr_cs_hold_ns | input | 16 | Write chip-select hold, 0 means one cycle |
| wr_strb_hold_ns | input | 16 | Write strobe hold, 0 means one cycle |
| rd_cs_setup_cyc | output | 7 | Read chip-select setup in cycles |
| rd_strb_setup_cyc | output | 7 | Read strobe setup in cycles |
| wr_cs_setup_cyc | output | 7 | Write chip-select setup in cycles |
| wr_strb_setup_cyc | output | 7 | Write strobe setup in cycles |
| rd_cs_width_cyc | output | 7 | Read chip-select width in cycles |
| rd_strb_width_cyc | output | 7 | Read strobe width in cycles |
| wr_cs_width_cyc | output | 7 | Write chip-select width in cycles |
| wr_strb_width_cyc | output | 7 | Write strobe width in cycles |
| rd_total_cyc | output | 7 | Extended read cycle in cycles |
| wr_total_cyc | output | 7 | Extended write cycle in cycles |
| overflow | output | 1 | Some output was clamped |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse: results valid |

## Verification
The `done` pulse of one calculation and the acceptance of the next `start` fall in the same cycle. `busy` is already low while `done` is high, so the bench raises `start` as soon as it sees `done`, on every run. It then checks that the new request is taken, that the previous results hold until the next `done`, and that the new latency is again exactly fifteen edges. A second overlap is also provoked: a `start` pulse with altered requests in the middle of a calculation. The bench judges it by comparing the finished results against the values computed from the requests latched first.

// File: rtl/smem_timing_calc.sv
module smem_timing_calc #(
  parameter int NS_W   = 16,
  parameter int FREQ_W = 32,
  parameter int CYC_W  = 7,
  parameter int ACC_W  = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [FREQ_W-1:0] freq_hz,
  input  logic [NS_W-1:0]  rd_cs_setup_ns,
  input  logic [NS_W-1:0]  rd_strb_setup_ns,
  input  logic [NS_W-1:0]  wr_cs_setup_ns,
  input  logic [NS_W-1:0]  wr_strb_setup_ns,
  input  logic [NS_W-1:0]  rd_cs_width_ns,
  input  logic [NS_W-1:0]  rd_strb_width_ns,
  input  logic [NS_W-1:0]  wr_cs_width_ns,
  input  logic [NS_W-1:0]  wr_strb_width_ns,
  input  logic [NS_W-1:0]  rd_total_ns,
  input  logic [NS_W-1:0]  wr_total_ns,
  input  logic [NS_W-1:0]  rd_cs_hold_ns,
  input  logic [NS_W-1:0]  rd_strb_hold_ns,
  input  logic [NS_W-1:0]  wr_cs_hold_ns,
  input  logic [NS_W-1:0]  wr_strb_hold_ns,
  output logic [CYC_W-1:0] rd_cs_setup_cyc,
  output logic [CYC_W-1:0] rd_strb_setup_cyc,
  output logic [CYC_W-1:0] wr_cs_setup_cyc,
  output logic [CYC_W-1:0] wr_strb_setup_cyc,
  output logic [CYC_W-1:0] rd_cs_width_cyc,
  output logic [CYC_W-1:0] rd_strb_width_cyc,
  output logic [CYC_W-1:0] wr_cs_width_cyc,
  output logic [CYC_W-1:0] wr_strb_width_cyc,
  output logic [CYC_W-1:0] rd_total_cyc,
  output logic [CYC_W-1:0] wr_total_cyc,
  output logic             overflow,
  output logic             busy,
  output logic             done
);
  localparam int N_IN  = 14;
  localparam int N_OUT = 10;
  localparam int IDX_W = $clog2(N_IN);
  localparam int FRAC  = 16;
  localparam int RW    = ACC_W - FRAC;
  localparam int SW    = RW + 2;
  localparam int FIRST_HOLD = 10;
  localparam logic [SW-1:0] CMAX = SW'((1 << CYC_W) - 1);

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_FIN} st_t;

  st_t              st;
  logic [IDX_W-1:0] idx;
  logic [ACC_W-1:0] scale_q;
  logic [NS_W-1:0]  req [N_IN];
  logic [NS_W-1:0]  inq [N_IN];
  logic [RW-1:0]    res [N_IN];
  logic [SW-1:0]    full [N_OUT];
  logic [CYC_W-1:0] outq [N_OUT];
  logic [N_OUT-1:0] clip;

  assign req[0]  = rd_cs_setup_ns;
  assign req[1]  = rd_strb_setup_ns;
  assign req[2]  = wr_cs_setup_ns;
  assign req[3]  = wr_strb_setup_ns;
  assign req[4]  = rd_cs_width_ns;
  assign req[5]  = rd_strb_width_ns;
  assign req[6]  = wr_cs_width_ns;
  assign req[7]  = wr_strb_width_ns;
  assign req[8]  = rd_total_ns;
  assign req[9]  = wr_total_ns;
  assign req[10] = rd_cs_hold_ns;
  assign req[11] = rd_strb_hold_ns;
  assign req[12] = wr_cs_hold_ns;
  assign req[13] = wr_strb_hold_ns;

  wire [ACC_W-1:0] scale_d =
    ((ACC_W'(freq_hz) / ACC_W'(10000)) << FRAC) / ACC_W'(100000);

  wire [NS_W-1:0]  sel   = inq[idx];
  wire [ACC_W-1:0] prod  = ACC_W'(sel) * scale_q;
  wire [ACC_W-1:0] round = prod + ACC_W'((1 << FRAC) - 1);
  wire             is_hold = (idx >= IDX_W'(FIRST_HOLD));
  wire [RW-1:0]    step  = (sel != '0) ? round[ACC_W-1:FRAC]
                                       : (is_hold ? RW'(1) : RW'(0));

  function automatic logic [SW-1:0] mx(input logic [SW-1:0] a, input logic [SW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [SW-1:0] leg(input logic [RW-1:0] s, input logic [RW-1:0] w,
                                        input logic [RW-1:0] h);
    return SW'(s) + SW'(w) + SW'(h);
  endfunction

  always_comb begin
    for (int i = 0; i < 8; i++) full[i] = SW'(res[i]);
    full[8] = mx(mx(SW'(res[8]), leg(res[0], res[4], res[10])), leg(res[1], res[5], res[11]));
    full[9] = mx(mx(SW'(res[9]), leg(res[2], res[6], res[12])), leg(res[3], res[7], res[13]));
    for (int i = 0; i < N_OUT; i++) clip[i] = full[i] > CMAX;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      scale_q  <= '0;
      done     <= 1'b0;
      overflow <= 1'b0;
      for (int i = 0; i < N_IN; i++) begin
        inq[i] <= '0;
        res[i] <= '0;
      end
      for (int i = 0; i < N_OUT; i++) outq[i] <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          for (int i = 0; i < N_IN; i++) inq[i] <= req[i];
          scale_q <= scale_d;
          idx     <= '0;
          st      <= S_CONV;
        end
        S_CONV: begin
          res[idx] <= step;
          if (idx == IDX_W'(N_IN - 1)) st <= S_FIN;
          else idx <= idx + 1'b1;
        end
        default: begin
          for (int i = 0; i < N_OUT; i++)
            outq[i] <= clip[i] ? CMAX[CYC_W-1:0] : full[i][CYC_W-1:0];
          overflow <= |clip;
          done     <= 1'b1;
          st       <= S_IDLE;
        end
      endcase
    end
  end

  assign busy              = (st != S_IDLE);
  assign rd_cs_setup_cyc   = outq[0];
  assign rd_strb_setup_cyc = outq[1];
  assign wr_cs_setup_cyc   = outq[2];
  assign wr_strb_setup_cyc = outq[3];
  assign rd_cs_width_cyc   = outq[4];
  assign rd_strb_width_cyc = outq[5];
  assign wr_cs_width_cyc   = outq[6];
  assign wr_strb_width_cyc = outq[7];
  assign rd_total_cyc      = outq[8];
  assign wr_total_cyc      = outq[9];
endmodule

module smem_timing_calc_chk #(
  parameter int CYC_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             overflow,
  input logic [CYC_W-1:0] rd_cs_setup_cyc,
  input logic [CYC_W-1:0] rd_cs_width_cyc,
  input logic [CYC_W-1:0] rd_strb_setup_cyc,
  input logic [CYC_W-1:0] rd_strb_width_cyc,
  input logic [CYC_W-1:0] wr_cs_setup_cyc,
  input logic [CYC_W-1:0] wr_cs_width_cyc,
  input logic [CYC_W-1:0] wr_strb_setup_cyc,
  input logic [CYC_W-1:0] wr_strb_width_cyc,
  input logic [CYC_W-1:0] rd_total_cyc,
  input logic [CYC_W-1:0] wr_total_cyc
);
  localparam int CMAX = (1 << CYC_W) - 1;

  function automatic int lim(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_after_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_idle_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_outputs_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(rd_total_cyc) && $stable(wr_total_cyc) && $stable(overflow)) |-> done);
  assert_flag_has_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (rd_total_cyc == CYC_W'(CMAX) || wr_total_cyc == CYC_W'(CMAX) ||
                  rd_cs_setup_cyc == CYC_W'(CMAX) || rd_strb_setup_cyc == CYC_W'(CMAX) ||
                  wr_cs_setup_cyc == CYC_W'(CMAX) || wr_strb_setup_cyc == CYC_W'(CMAX) ||
                  rd_cs_width_cyc == CYC_W'(CMAX) || rd_strb_width_cyc == CYC_W'(CMAX) ||
                  wr_cs_width_cyc == CYC_W'(CMAX) || wr_strb_width_cyc == CYC_W'(CMAX)));
  assert_read_covers_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(rd_total_cyc) >= lim(int'(rd_cs_setup_cyc) + int'(rd_cs_width_cyc)) &&
              int'(rd_total_cyc) >= lim(int'(rd_strb_setup_cyc) + int'(rd_strb_width_cyc))));
  assert_write_covers_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(wr_total_cyc) >= lim(int'(wr_cs_setup_cyc) + int'(wr_cs_width_cyc)) &&
              int'(wr_total_cyc) >= lim(int'(wr_strb_setup_cyc) + int'(wr_strb_width_cyc))));
endmodule

bind smem_timing_calc smem_timing_calc_chk #(.CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .overflow(overflow),
  .rd_cs_setup_cyc(rd_cs_setup_cyc), .rd_cs_width_cyc(rd_cs_width_cyc),
  .rd_strb_setup_cyc(rd_strb_setup_cyc), .rd_strb_width_cyc(rd_strb_width_cyc),
  .wr_cs_setup_cyc(wr_cs_setup_cyc), .wr_cs_width_cyc(wr_cs_width_cyc),
  .wr_strb_setup_cyc(wr_strb_setup_cyc), .wr_strb_width_cyc(wr_strb_width_cyc),
  .rd_total_cyc(rd_total_cyc), .wr_total_cyc(wr_total_cyc)
);

// File: tb/smem_timing_calc_bench.sv
module smem_timing_calc_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] freq = 32'd0;
  logic [15:0] ns_in [14];
  logic [6:0]  cyc [10];
  logic overflow, busy, done;
  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  smem_timing_calc u_smem_timing_calc (
    .clk(clk), .rst_n(rst_n), .start(start), .freq_hz(freq),
    .rd_cs_setup_ns(ns_in[0]), .rd_strb_setup_ns(ns_in[1]),
    .wr_cs_setup_ns(ns_in[2]), .wr_strb_setup_ns(ns_in[3]),
    .rd_cs_width_ns(ns_in[4]), .rd_strb_width_ns(ns_in[5]),
    .wr_cs_width_ns(ns_in[6]), .wr_strb_width_ns(ns_in[7]),
    .rd_total_ns(ns_in[8]), .wr_total_ns(ns_in[9]),
    .rd_cs_hold_ns(ns_in[10]), .rd_strb_hold_ns(ns_in[11]),
    .wr_cs_hold_ns(ns_in[12]), .wr_strb_hold_ns(ns_in[13]),
    .rd_cs_setup_cyc(cyc[0]), .rd_strb_setup_cyc(cyc[1]),
    .wr_cs_setup_cyc(cyc[2]), .wr_strb_setup_cyc(cyc[3]),
    .rd_cs_width_cyc(cyc[4]), .rd_strb_width_cyc(cyc[5]),
    .wr_cs_width_cyc(cyc[6]), .wr_strb_width_cyc(cyc[7]),
    .rd_total_cyc(cyc[8]), .wr_total_cyc(cyc[9]),
    .overflow(overflow), .busy(busy), .done(done)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint cv(input longint x, input longint sc, input bit hold);
    if (x == 0) return hold ? 1 : 0;
    return (x * sc + 65535) >>> 16;
  endfunction

  function automatic longint mx3(input longint a, input longint b, input longint c);
    longint m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

  task automatic run(input bit disturb);
    longint sc, f[14], e[10];
    bit ov = 0;
    int cnt = 0;
    logic [6:0] prev_rd = cyc[8];
    bit held = 1;
    sc = ((longint'(freq) / 10000) << 16) / 100000;
    for (int i = 0; i < 14; i++) f[i] = cv(longint'(ns_in[i]), sc, i >= 10);
    for (int i = 0; i < 8; i++) e[i] = f[i];
    e[8] = mx3(f[8], f[0] + f[4] + f[10], f[1] + f[5] + f[11]);
    e[9] = mx3(f[9], f[2] + f[6] + f[12], f[3] + f[7] + f[13]);
    for (int i = 0; i < 10; i++) if (e[i] > 127) begin e[i] = 127; ov = 1; end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 1;
    check("R7 busy after start", busy, 1);
    while (!done && cnt < 60) begin
      @(negedge clk);
      cnt++;
      if (!done && cyc[8] != prev_rd) held = 0;
      if (disturb && cnt == 3) begin
        start = 1'b1;
        freq = freq + 32'd77000000;
        for (int i = 0; i < 14; i++) ns_in[i] = ns_in[i] + 16'd999;
      end
      if (disturb && cnt == 4) start = 1'b0;
    end
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R7 watchdog actual=no done expected=done");
      return;
    end
    check("R7 latency", cnt, 16);
    check("R7 outputs held until done", held, 1);
    check("R7 busy low at done", busy, 0);
    for (int i = 0; i < 8; i++)
      check((i >= 4) ? "R1 width conversion" : "R2 setup conversion", cyc[i], e[i]);
    check(disturb ? "R8 read total after ignored start" : "R4 read total", cyc[8], e[8]);
    check(disturb ? "R8 write total after ignored start" : "R5 write total", cyc[9], e[9]);
    check("R6 overflow flag", overflow, ov);
  endtask

  initial begin
    #1000000;
    n_tests++; n_fail++;
    $display("FAIL R7 global watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 14; i++) ns_in[i] = 16'd0;
    repeat (3) @(negedge clk);
    check("R9 reset busy", busy, 0);
    check("R9 reset done", done, 0);
    check("R9 reset overflow", overflow, 0);
    check("R9 reset read total", cyc[8], 0);
    rst_n = 1'b1;
    @(negedge clk);

    freq = 32'd100000000;
    run(0);
    check("R3 zero hold gives one cycle read total", cyc[8], 1);
    check("R2 zero setup", cyc[0], 0);

    ns_in[0] = 16'd30; ns_in[4] = 16'd50; ns_in[10] = 16'd40; ns_in[8] = 16'd20;
    ns_in[3] = 16'd10; ns_in[7] = 16'd15; ns_in[9] = 16'd200;
    run(0);
    check("R1 ceiling 10ns at 100MHz", cyc[3], 1);

    freq = 32'd200000000;
    ns_in[8] = 16'd60000;
    run(0);
    check("R6 clamp read total", cyc[8], 127);

    freq = 32'd50000000;
    for (int i = 0; i < 14; i++) ns_in[i] = 16'($urandom_range(0, 90));
    run(1);

    for (int k = 0; k < 40; k++) begin
      freq = $urandom_range(1000000, 250000000);
      for (int i = 0; i < 14; i++) begin
        if ($urandom_range(0, 5) == 0) ns_in[i] = 16'd0;
        else if ($urandom_range(0, 20) == 0) ns_in[i] = 16'($urandom_range(0, 65535));
        else ns_in[i] = 16'($urandom_range(1, 120));
      end
      run(k % 8 == 3);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule